// File: doc/BRIEF.md
# Flash Write-Status Reporter

This block forms the word a host sees when it reads a flash array while an internal program or erase job is running, or while an erase has been put on hold. A sequencer elsewhere supplies the job type, a busy flag, a suspend flag, the word being programmed and the index of the suspended region. The array supplies the word stored at the read address. On every read strobe the block returns either that array word or a status word in which three bits carry progress information: a polling bit (bit 7), a main toggle bit (bit 6) and a region toggle bit (bit 2).

Polling works on complemented data during a program and on a fixed zero during an erase. The two toggle bits have separate flip-flops, so software can tell an active erase from a suspended one, and can tell which region is on hold. An active-low ready/busy output follows the busy flag. Array storage, command decoding and job timing belong to other blocks.

Top module: `flash_wstat_top`

## Requirements
- R1: While `job_busy`=1 and `job_kind`=0 (program), a read returns bit 7 equal to the inverse of bit 7 of `prog_word`. This applies whether or not `erase_susp` is set.
- R2: While `job_busy`=1, `job_kind`=1 (erase) and `erase_susp`=0, a read returns bit 7 = 0. Once the job ends, reads return the array word.
- R3: While a program or a running erase is in progress, bit 6 reads 0 on the first read after the job starts. It then inverts on each further read strobe.
- R4: Bit 2 inverts on each read while an erase is running. During a program it carries bit 2 of the array word.
- R5: With `erase_susp`=1 and no program running, a read whose address bits above `REGION_LSB` equal `susp_region` returns bit 7 = 1 and bit 6 = 1. Bit 2 toggles on each such read. The suspend flag takes precedence over an erase-busy indication.
- R6: With `erase_susp`=1 and no program running, a read outside the suspended region returns the array word and does not advance the bit 2 toggle. `rdy_busy_n` is 1 in this state.
- R7: A program running during suspend reports as in R1 and R3, and `rdy_busy_n` is 0.
- R8: `rdy_busy_n` equals the inverse of `job_busy` as sampled one clock earlier.
- R9: The bit 6 toggle clears whenever no program and no running erase is present. The bit 2 toggle clears whenever there is neither a running erase nor a suspended erase without a program, so the first read of the next job starts at 0.
- R10: All bits of a status word other than 7, 6 and 2 come from the array word. `rd_data` and `rd_valid` update one clock after a strobe. Without a strobe, `rd_valid` is 0 and `rd_data` holds its value.
- R11: Under reset, `rd_data` is 0, `rd_valid` is 0 and `rdy_busy_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| job_kind | input | 1 | 0 = program, 1 = erase |
| job_busy | input | 1 | Internal job in progress |
| erase_susp | input | 1 | An erase is suspended |
| prog_word | input | DATA_W | Word being programmed |
| susp_region | input | ADDR_W-REGION_LSB | Index of the suspended region |
| rd_stb | input | 1 | Read strobe, one cycle |
| rd_addr | input | ADDR_W | Read address |
| array_word | input | DATA_W | Array contents at `rd_addr` |
| rd_data | output | DATA_W | Returned read word |
| rd_valid | output | 1 | `rd_data` updated this cycle |
| rdy_busy_n | output | 1 | High = ready, low = job in progress |

## Verification
Two events can fall in the same cycle: a read strobe and the edge where a job ends or a new one starts. When that happens, the toggle clear and the toggle advance compete in one flip-flop, and the word must be formed from the new job state. The bench provokes this by changing job flags and strobing in the same cycle at every configuration switch, including the sequence program, then end, then program. It judges the result against a model that applies the clear-before-advance rule and expects bit 6 = 0 on the first read of the new job.

// File: rtl/flash_wstat_pkg.sv
// Shared types for the write-status reporter.
// Assumes: job_kind encodes program as 0 and erase as 1.
package flash_wstat_pkg;

    typedef enum logic [2:0] {
        MODE_IDLE,
        MODE_PROG,
        MODE_ERASE,
        MODE_SUSP_HIT,
        MODE_SUSP_MISS
    } stat_mode_e;

    localparam logic JOB_PROG  = 1'b0;
    localparam logic JOB_ERASE = 1'b1;

endpackage

// File: rtl/flash_wstat_mode_sel.sv
// Classifies the current read into one status mode.
// Purely combinational. Assumes the sequencer keeps job flags stable
// across a read strobe. A program outranks suspend, and suspend
// outranks a stale erase-busy flag.
module flash_wstat_mode_sel
    import flash_wstat_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int REGION_LSB = 4,
    localparam int REG_W     = ADDR_W - REGION_LSB
) (
    input  logic              job_kind,
    input  logic              job_busy,
    input  logic              erase_susp,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [REG_W-1:0]  susp_region,
    output stat_mode_e        mode,
    output logic              region_hit
);

    // Compare the region part of the address with the held region.
    always_comb region_hit = (rd_addr[ADDR_W-1:REGION_LSB] == susp_region);

    // Priority decode of job flags into a mode.
    always_comb begin
        if (job_busy && job_kind == JOB_PROG)
            mode = MODE_PROG;
        else if (erase_susp)
            mode = region_hit ? MODE_SUSP_HIT : MODE_SUSP_MISS;
        else if (job_busy)
            mode = MODE_ERASE;
        else
            mode = MODE_IDLE;
    end

endmodule

// File: rtl/flash_wstat_toggle.sv
// One toggle flip-flop: inverts on adv, and clr has priority.
// Assumes clr and adv come from the same-cycle mode decode.
module flash_wstat_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic q
);

    // Toggle state with priority clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            q <= 1'b0;
        else if (adv)
            q <= ~q;
    end

    AST_TOG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !q);                                          // R9
    AST_TOG_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr) |=> (q != $past(q)));                   // R3

endmodule

// File: rtl/flash_wstat_word_mux.sv
// Forms the returned word from the mode and toggle states, and
// registers it on a read strobe.
// Assumes bit positions are distinct and inside DATA_W.
module flash_wstat_word_mux
    import flash_wstat_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int POLL_BIT = 7,
    parameter int TOG_BIT  = 6,
    parameter int AUX_BIT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stat_mode_e        mode,
    input  logic              tog_main,
    input  logic              tog_aux,
    input  logic [DATA_W-1:0] array_word,
    input  logic [DATA_W-1:0] prog_word,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    logic [DATA_W-1:0] word_next;

    // Overlay status bits on the array word according to mode.
    always_comb begin
        word_next = array_word;
        unique case (mode)
            MODE_PROG: begin
                word_next[POLL_BIT] = ~prog_word[POLL_BIT];
                word_next[TOG_BIT]  = tog_main;
            end
            MODE_ERASE: begin
                word_next[POLL_BIT] = 1'b0;
                word_next[TOG_BIT]  = tog_main;
                word_next[AUX_BIT]  = tog_aux;
            end
            MODE_SUSP_HIT: begin
                word_next[POLL_BIT] = 1'b1;
                word_next[TOG_BIT]  = 1'b1;
                word_next[AUX_BIT]  = tog_aux;
            end
            default: word_next = array_word;
        endcase
    end

    // Capture the word on a strobe and pulse valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_stb;
            if (rd_stb)
                rd_data <= word_next;
        end
    end

    AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> (!rd_valid && $stable(rd_data)));         // R10

endmodule

// File: rtl/flash_wstat_top.sv
// Write-status reporter top: mode decode, two toggle flops, word
// formation and a registered ready/busy output.
// Assumes rd_stb is a single-cycle pulse and array_word matches rd_addr
// in the strobe cycle.
module flash_wstat_top
    import flash_wstat_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 8,
    parameter int REGION_LSB = 4,
    parameter int POLL_BIT   = 7,
    parameter int TOG_BIT    = 6,
    parameter int AUX_BIT    = 2,
    localparam int REG_W     = ADDR_W - REGION_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              job_kind,
    input  logic              job_busy,
    input  logic              erase_susp,
    input  logic [DATA_W-1:0] prog_word,
    input  logic [REG_W-1:0]  susp_region,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] array_word,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rdy_busy_n
);

    stat_mode_e mode;
    logic       region_hit;
    logic       tog_main, tog_aux;
    logic       main_live, aux_live, aux_step;

    flash_wstat_mode_sel #(
        .ADDR_W     (ADDR_W),
        .REGION_LSB (REGION_LSB)
    ) mode_i (
        .job_kind    (job_kind),
        .job_busy    (job_busy),
        .erase_susp  (erase_susp),
        .rd_addr     (rd_addr),
        .susp_region (susp_region),
        .mode        (mode),
        .region_hit  (region_hit)
    );

    // Decide which toggle flops are live and which may advance.
    always_comb begin
        main_live = (mode == MODE_PROG) || (mode == MODE_ERASE);
        aux_live  = (mode == MODE_ERASE) || (mode == MODE_SUSP_HIT)
                 || (mode == MODE_SUSP_MISS);
        aux_step  = (mode == MODE_ERASE) || (mode == MODE_SUSP_HIT);
    end

    flash_wstat_toggle main_tog_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!main_live),
        .adv   (rd_stb && main_live),
        .q     (tog_main)
    );

    flash_wstat_toggle aux_tog_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!aux_live),
        .adv   (rd_stb && aux_step),
        .q     (tog_aux)
    );

    flash_wstat_word_mux #(
        .DATA_W   (DATA_W),
        .POLL_BIT (POLL_BIT),
        .TOG_BIT  (TOG_BIT),
        .AUX_BIT  (AUX_BIT)
    ) mux_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .tog_main   (tog_main),
        .tog_aux    (tog_aux),
        .array_word (array_word),
        .prog_word  (prog_word),
        .rd_stb     (rd_stb),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );

    // Registered ready/busy, high (ready) out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdy_busy_n <= 1'b1;
        else
            rdy_busy_n <= !job_busy;
    end

    AST_PROG_POLL_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && job_busy && job_kind == JOB_PROG)
        |=> (rd_data[POLL_BIT] == !$past(prog_word[POLL_BIT])));          // R1
    AST_ERASE_POLL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && job_busy && job_kind == JOB_ERASE && !erase_susp)
        |=> !rd_data[POLL_BIT]);                                          // R2
    AST_SUSP_HIT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !job_busy && erase_susp
         && rd_addr[ADDR_W-1:REGION_LSB] == susp_region)
        |=> (rd_data[POLL_BIT] && rd_data[TOG_BIT]));                     // R5
    AST_IDLE_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !job_busy && !erase_susp)
        |=> (rd_data == $past(array_word)));                              // R2
    AST_READY_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rdy_busy_n == !$past(job_busy)));               // R8

endmodule

// File: tb/flash_wstat_top_tb_top.sv
// Bench: sweeps every address under each job configuration on a
// small instance, with an arithmetic array image and a toggle model.
module flash_wstat_top_tb_top;

    localparam int DW = 16;
    localparam int AW = 6;
    localparam int RL = 3;
    localparam int RW = AW - RL;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          job_kind, job_busy, erase_susp;
    logic [DW-1:0] prog_word;
    logic [RW-1:0] susp_region;
    logic          rd_stb;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] array_word;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic          rdy_busy_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic          m_t6, m_t2;
    logic [DW-1:0] last_data;

    always #4 clk = ~clk;

    flash_wstat_top #(
        .DATA_W (DW), .ADDR_W (AW), .REGION_LSB (RL),
        .POLL_BIT (7), .TOG_BIT (6), .AUX_BIT (2)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .job_kind (job_kind),
        .job_busy (job_busy), .erase_susp (erase_susp),
        .prog_word (prog_word), .susp_region (susp_region),
        .rd_stb (rd_stb), .rd_addr (rd_addr), .array_word (array_word),
        .rd_data (rd_data), .rd_valid (rd_valid), .rdy_busy_n (rdy_busy_n)
    );

    function automatic logic [DW-1:0] arr(input logic [AW-1:0] a);
        return 16'(a * 16'h0925 + 16'h1357);
    endfunction

    always_comb array_word = arr(rd_addr);

    function automatic string tag_of();
        if (job_busy && !job_kind) return erase_susp ? "R7" : "R1";
        if (erase_susp)
            return (rd_addr[AW-1:RL] == susp_region) ? "R5" : "R6";
        if (job_busy) return "R2";
        return "R10";
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: optional strobe at rd_addr, then check all outputs.
    task automatic step(input logic stb);
        logic [DW-1:0] e;
        logic prog_on, erase_on, susp_on, hit;
        string tg;
        prog_on  = job_busy && !job_kind;
        erase_on = job_busy && job_kind && !erase_susp;
        susp_on  = erase_susp && !prog_on;
        hit      = (rd_addr[AW-1:RL] == susp_region);
        tg       = tag_of();
        e = arr(rd_addr);
        if (prog_on) begin
            e[7] = ~prog_word[7]; e[6] = m_t6;            // R1 R3 R4
        end else if (erase_on) begin
            e[7] = 1'b0; e[6] = m_t6; e[2] = m_t2;       // R2 R3 R4
        end else if (susp_on && hit) begin
            e[7] = 1'b1; e[6] = 1'b1; e[2] = m_t2;       // R5
        end
        // Model toggles: clear has priority over advance (R9).
        if (!(prog_on || erase_on)) m_t6 = 1'b0;
        else if (stb) m_t6 = ~m_t6;
        if (!(erase_on || susp_on)) m_t2 = 1'b0;
        else if (stb && (erase_on || (susp_on && hit))) m_t2 = ~m_t2;
        rd_stb = stb;
        @(posedge clk);
        @(negedge clk);
        rd_stb = 1'b0;
        if (stb) begin
            check(tg, rd_data, e);
            last_data = e;
        end else begin
            check("R10", rd_data, last_data);
        end
        check("R10", {15'd0, rd_valid}, {15'd0, stb});
        check("R8", {15'd0, rdy_busy_n}, {15'd0, !job_busy});
    endtask

    task automatic set_job(input logic k, input logic b, input logic s,
                           input logic [DW-1:0] pw, input logic [RW-1:0] rg);
        job_kind = k; job_busy = b; erase_susp = s;
        prog_word = pw; susp_region = rg;
    endtask

    initial begin
        rst_n = 1'b0; rd_stb = 1'b0; rd_addr = '0;
        set_job(1'b0, 1'b1, 1'b0, '0, '0);
        m_t6 = 1'b0; m_t2 = 1'b0; last_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11", rd_data, '0);
        check("R11", {15'd0, rd_valid}, 16'd0);
        check("R11", {15'd0, rdy_busy_n}, 16'd1);
        rst_n = 1'b1;
        set_job(1'b0, 1'b0, 1'b0, '0, '0);
        step(1'b0);

        // Sweep configurations: idle, program, erase, suspend,
        // program in suspend, erase-busy with suspend set.
        for (int cfg = 0; cfg < 6; cfg++) begin
            logic [DW-1:0] pw;
            pw = 16'h5A3C ^ 16'(cfg << 7);
            case (cfg)
                0: set_job(1'b0, 1'b0, 1'b0, pw, RW'(cfg + 1));
                1: set_job(1'b0, 1'b1, 1'b0, pw, RW'(cfg + 1));
                2: set_job(1'b1, 1'b1, 1'b0, pw, RW'(cfg + 1));
                3: set_job(1'b1, 1'b0, 1'b1, pw, RW'(cfg + 1));
                4: set_job(1'b0, 1'b1, 1'b1, pw, RW'(cfg + 1));
                default: set_job(1'b1, 1'b1, 1'b1, pw, RW'(cfg + 1));
            endcase
            for (int a = 0; a < (1 << AW); a++) begin
                rd_addr = AW'(a);
                step(1'b1);
                if (a % 5 == 0) step(1'b0);
            end
        end

        // Coincidence: program ends and restarts in strobe cycles (R9).
        set_job(1'b0, 1'b1, 1'b0, 16'h0080, '0);
        rd_addr = 6'd9;
        step(1'b1); step(1'b1); step(1'b1);
        set_job(1'b0, 1'b0, 1'b0, 16'h0080, '0);
        step(1'b1);
        set_job(1'b0, 1'b1, 1'b0, 16'h0000, '0);
        step(1'b1); step(1'b1);
        // Suspend resumes erase: aux toggle carries on (R4, R9).
        set_job(1'b1, 1'b0, 1'b1, '0, 3'd1);
        rd_addr = 6'd10;
        step(1'b1); step(1'b1); step(1'b1);
        set_job(1'b1, 1'b1, 1'b0, '0, 3'd1);
        step(1'b1); step(1'b1);
        set_job(1'b1, 1'b0, 1'b0, '0, 3'd1);
        step(1'b1); step(1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule